// File: doc/BRIEF.md
# MEI Cache-Line Coherence Controller

This block tracks the coherence state of a single data-cache line under a three-state protocol with Modified, Exclusive and Invalid states. A processor-side front end reports what its lookup found (read hit, read miss, write hit or write miss) as single-cycle strobes. A bus-side snooper reports a snoop hit from another master's cacheable read or write. The controller moves the line between states and raises a fill request when a miss must bring the block in, or a push request when a snooped dirty line must be written back first.

Because there is no shared state, every fill ends in an exclusive form. A read fill ends in Exclusive and a write fill ends in Modified. A snoop on a dirty line always costs a write-back and then an invalidation. While a fill or push is outstanding, or while a snoop strobe is present, the controller raises `busy`. During that time it drops processor events, so the front end must present them again. A snoop wins over a processor event that arrives in the same cycle, because the tag lookup has a single port.

Top module: `mei_line_ctrl`

## Requirements
- R1: `line_state` only ever shows Invalid = 2'b00, Exclusive = 2'b01 or Modified = 2'b10; the value 2'b11 never appears.
- R2: While `rst_n` is low at a rising clock edge, the controller enters Invalid with `fill_req` and `push_req` low, and `busy` is low once the strobes are idle.
- R3: A read miss taken on an Invalid line raises `fill_req` after the next edge, with the state left Invalid. A `fill_done` taken while that request is pending moves the line to Exclusive and drops `fill_req` after that edge.
- R4: A write miss taken on an Invalid line raises `fill_req`. The matching `fill_done` moves the line to Modified and drops `fill_req`.
- R5: A write hit taken on an Exclusive line moves it to Modified after the next edge, with no request raised. A write hit on a Modified line leaves it Modified.
- R6: A read hit leaves an Exclusive or Modified line unchanged and raises no request.
- R7: A snoop hit taken on a Modified line raises `push_req` after the next edge, and the line stays Modified until `push_done`. After `push_done` the line is Invalid and `push_req` is low.
- R8: A snoop hit taken on an Exclusive line moves it to Invalid after the next edge, with no push.
- R9: A snoop hit on an Invalid line changes nothing and raises neither request.
- R10: `busy` is high whenever a fill or push is pending or `snp_hit` is high. Processor events seen while `busy` is high are ignored. A snoop arriving with a processor event in the same cycle is the one taken.
- R11: A cycle with more than one processor strobe high is ignored. Hits on an Invalid line and misses on a valid line are also ignored.
- R12: `fill_done` or `push_done` with no matching pending request is ignored. A snoop during a pending fill or push has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rd_hit | input | 1 | Processor read found the line valid |
| ev_rd_miss | input | 1 | Processor read missed the line |
| ev_wr_hit | input | 1 | Processor write found the line valid |
| ev_wr_miss | input | 1 | Processor write missed the line |
| snp_hit | input | 1 | Another master's cacheable read or write matched this line |
| fill_done | input | 1 | The requested block fill has completed |
| push_done | input | 1 | The requested write-back has completed |
| line_state | output | 2 | Current coherence state (00 Invalid, 01 Exclusive, 10 Modified) |
| fill_req | output | 1 | Block fill outstanding |
| push_req | output | 1 | Snoop write-back outstanding |
| busy | output | 1 | Processor events are being refused this cycle |

## Verification
Each processor event is applied in each of the three states. This separates the accepted transitions from the ones that must be ignored, such as a miss on a valid line or a hit on an Invalid one. Snoops are applied to Invalid, Exclusive and Modified lines, which distinguishes the no-op, the silent invalidation and the push-then-invalidate sequence. Overlap patterns pair a snoop with a processor strobe in one cycle, pair several processor strobes together, send events during pending fills and pushes, and send handshakes with no request. These show whether arbitration and hold-off are applied correctly, rather than the event merely landing a cycle late.

// File: rtl/mei_pkg.sv
// Shared types for the single-line coherence controller.
// Assumes: state codes are visible at the top port and must stay fixed.
package mei_pkg;

    // Coherence state of the tracked line; 2'b11 is never produced.
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_EXC = 2'b01,
        LS_MOD = 2'b10
    } line_st_e;

    // Event selected by the arbiter for the current cycle.
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_RD_HIT  = 3'd1,
        EV_RD_MISS = 3'd2,
        EV_WR_HIT  = 3'd3,
        EV_WR_MISS = 3'd4,
        EV_SNOOP   = 3'd5
    } line_ev_e;

    // Number of processor event strobes (read hit, read miss, write hit, write miss).
    localparam int unsigned CPU_EV_N = 4;

endpackage

// File: rtl/mei_event_arbiter.sv
// Picks at most one event per cycle for the line state logic.
// A snoop beats processor events; nothing is taken while a fill or push
// is pending; a processor vector that is not one-hot is dropped.
// Assumes: cpu_ev bit order is rd_hit, rd_miss, wr_hit, wr_miss (bit 0 up).
module mei_event_arbiter
    import mei_pkg::*;
#(
    parameter int unsigned N_CPU = CPU_EV_N
) (
    input  logic [N_CPU-1:0] cpu_ev,
    input  logic             snoop,
    input  logic             pend,
    output line_ev_e         ev_sel,
    output logic             busy
);

    localparam int unsigned CW = $clog2(N_CPU + 1);
    localparam int unsigned IW = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    logic [CW-1:0] ones;
    logic [IW-1:0] idx;

    // Population count and index of the highest set processor strobe.
    always_comb begin
        ones = '0;
        idx  = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (cpu_ev[i]) begin
                ones = ones + CW'(1);
                idx  = IW'(i);
            end
        end
    end

    // Arbitration: pending transaction blocks all, snoop first, then one-hot processor event.
    always_comb begin
        ev_sel = EV_NONE;
        if (!pend) begin
            if (snoop) begin
                ev_sel = EV_SNOOP;
            end else if (ones == CW'(1)) begin
                case (idx)
                    IW'(0):  ev_sel = EV_RD_HIT;
                    IW'(1):  ev_sel = EV_RD_MISS;
                    IW'(2):  ev_sel = EV_WR_HIT;
                    IW'(3):  ev_sel = EV_WR_MISS;
                    default: ev_sel = EV_NONE;
                endcase
            end
        end
    end

    // Processor side is refused while a transaction is open or a snoop owns the tags.
    always_comb busy = pend | snoop;

endmodule

// File: rtl/mei_txn_tracker.sv
// Holds the outstanding fill and push requests and the state a fill lands in.
// Assumes: start_fill and start_push are only raised when nothing is pending,
// and a done strobe is meaningful only while its own request is open.
module mei_txn_tracker
    import mei_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_fill,
    input  line_st_e fill_tgt,
    input  logic     start_push,
    input  logic     fill_done,
    input  logic     push_done,
    output logic     fill_req,
    output logic     push_req,
    output logic     fill_fin,
    output logic     push_fin,
    output line_st_e land_st
);

    logic     fill_q;
    logic     push_q;
    line_st_e tgt_q;

    // Completion is only recognised against an open request.
    always_comb begin
        fill_fin = fill_q & fill_done;
        push_fin = push_q & push_done;
    end

    // Fill request flag and its landing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b0;
            tgt_q  <= LS_INV;
        end else if (fill_fin) begin
            fill_q <= 1'b0;
        end else if (start_fill) begin
            fill_q <= 1'b1;
            tgt_q  <= fill_tgt;
        end
    end

    // Push request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 1'b0;
        end else if (push_fin) begin
            push_q <= 1'b0;
        end else if (start_push) begin
            push_q <= 1'b1;
        end
    end

    // Drive outputs from the flags.
    always_comb begin
        fill_req = fill_q;
        push_req = push_q;
        land_st  = tgt_q;
    end

endmodule

// File: rtl/mei_state_reg.sv
// Line state register and the protocol transitions.
// Assumes: ev_sel is EV_NONE whenever a fill or push is open, so completions
// and new events never coincide.
module mei_state_reg
    import mei_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  line_ev_e ev_sel,
    input  logic     fill_fin,
    input  logic     push_fin,
    input  line_st_e land_st,
    output line_st_e st,
    output logic     start_fill,
    output line_st_e fill_tgt,
    output logic     start_push
);

    line_st_e st_q;
    line_st_e st_d;

    // Next state and transaction launches for the selected event.
    always_comb begin
        st_d       = st_q;
        start_fill = 1'b0;
        start_push = 1'b0;
        fill_tgt   = LS_EXC;
        if (fill_fin) begin
            st_d = land_st;
        end else if (push_fin) begin
            st_d = LS_INV;
        end else begin
            case (ev_sel)
                EV_RD_MISS: begin
                    if (st_q == LS_INV) begin
                        start_fill = 1'b1;
                        fill_tgt   = LS_EXC;
                    end
                end
                EV_WR_MISS: begin
                    if (st_q == LS_INV) begin
                        start_fill = 1'b1;
                        fill_tgt   = LS_MOD;
                    end
                end
                EV_WR_HIT: begin
                    if (st_q == LS_EXC) st_d = LS_MOD;
                end
                EV_SNOOP: begin
                    if (st_q == LS_MOD)      start_push = 1'b1;
                    else if (st_q == LS_EXC) st_d = LS_INV;
                end
                default: st_d = st_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LS_INV;
        else        st_q <= st_d;
    end

    // Expose current state.
    always_comb st = st_q;

endmodule

// File: rtl/mei_line_ctrl.sv
// Top of the single-line Modified/Exclusive/Invalid coherence controller.
// Assumes: strobes are single-cycle and synchronous to clk; the fill and
// push agents hold their done strobe for one cycle per request.
module mei_line_ctrl
    import mei_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_rd_hit,
    input  logic       ev_rd_miss,
    input  logic       ev_wr_hit,
    input  logic       ev_wr_miss,
    input  logic       snp_hit,
    input  logic       fill_done,
    input  logic       push_done,
    output logic [1:0] line_state,
    output logic       fill_req,
    output logic       push_req,
    output logic       busy
);

    logic [CPU_EV_N-1:0] cpu_ev;
    line_ev_e            ev_sel;
    line_st_e            st;
    line_st_e            fill_tgt;
    line_st_e            land_st;
    logic                start_fill;
    logic                start_push;
    logic                fill_fin;
    logic                push_fin;
    logic                fill_q;
    logic                push_q;
    logic                pend;

    // Pack processor strobes in arbiter bit order and note open transactions.
    always_comb begin
        cpu_ev = {ev_wr_miss, ev_wr_hit, ev_rd_miss, ev_rd_hit};
        pend   = fill_q | push_q;
    end

    mei_event_arbiter #(.N_CPU(CPU_EV_N)) arb_i (
        .cpu_ev (cpu_ev),
        .snoop  (snp_hit),
        .pend   (pend),
        .ev_sel (ev_sel),
        .busy   (busy)
    );

    mei_state_reg st_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_sel     (ev_sel),
        .fill_fin   (fill_fin),
        .push_fin   (push_fin),
        .land_st    (land_st),
        .st         (st),
        .start_fill (start_fill),
        .fill_tgt   (fill_tgt),
        .start_push (start_push)
    );

    mei_txn_tracker trk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_fill (start_fill),
        .fill_tgt   (fill_tgt),
        .start_push (start_push),
        .fill_done  (fill_done),
        .push_done  (push_done),
        .fill_req   (fill_q),
        .push_req   (push_q),
        .fill_fin   (fill_fin),
        .push_fin   (push_fin),
        .land_st    (land_st)
    );

    // Drive top outputs.
    always_comb begin
        line_state = st;
        fill_req   = fill_q;
        push_req   = push_q;
    end

endmodule

// File: rtl/mei_line_ctrl_chk.sv
// Protocol checker for mei_line_ctrl, attached by bind; observes ports only.
module mei_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_rd_hit,
    input logic       ev_rd_miss,
    input logic       ev_wr_hit,
    input logic       ev_wr_miss,
    input logic       snp_hit,
    input logic       fill_done,
    input logic       push_done,
    input logic [1:0] line_state,
    input logic       fill_req,
    input logic       push_req,
    input logic       busy
);

    logic [3:0] cpu;
    logic       idle;
    always_comb begin
        cpu  = {ev_wr_miss, ev_wr_hit, ev_rd_miss, ev_rd_hit};
        idle = !fill_req && !push_req;
    end

    // R1
    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        line_state != 2'b11);

    // R2
    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (line_state == 2'b00 && !fill_req && !push_req));

    // R3
    a_r3_rd_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_state == 2'b00 && cpu == 4'b0010) |=> (fill_req && line_state == 2'b00));

    // R4
    a_r4_wr_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_state == 2'b00 && cpu == 4'b1000) |=> fill_req);

    // R5
    a_r5_wr_hit_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_state == 2'b01 && cpu == 4'b0100) |=> (line_state == 2'b10 && !fill_req && !push_req));

    // R6
    a_r6_rd_hit_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_state != 2'b00 && cpu == 4'b0001) |=> ($stable(line_state) && !fill_req && !push_req));

    // R7
    a_r7_snoop_push: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && snp_hit && line_state == 2'b10) |=> (push_req && line_state == 2'b10));

    a_r7_push_end: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_done) |=> (line_state == 2'b00 && !push_req));

    // R8
    a_r8_snoop_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && snp_hit && line_state == 2'b01) |=> (line_state == 2'b00 && !push_req));

    // R9
    a_r9_snoop_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && snp_hit && line_state == 2'b00) |=> (line_state == 2'b00 && !push_req && !fill_req));

    // R10
    a_r10_busy_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req || push_req || snp_hit) |-> busy);

    a_r10_single_txn: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && push_req));

    // R12
    a_r12_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_done) |=> ($stable(line_state) && fill_req && !push_req));

endmodule

bind mei_line_ctrl mei_line_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_rd_hit  (ev_rd_hit),
    .ev_rd_miss (ev_rd_miss),
    .ev_wr_hit  (ev_wr_hit),
    .ev_wr_miss (ev_wr_miss),
    .snp_hit    (snp_hit),
    .fill_done  (fill_done),
    .push_done  (push_done),
    .line_state (line_state),
    .fill_req   (fill_req),
    .push_req   (push_req),
    .busy       (busy)
);

// File: tb/mei_line_ctrl_tb_top.sv
// Directed bench for mei_line_ctrl: one task per scenario, each checking itself.
module mei_line_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_rd_hit = 1'b0, ev_rd_miss = 1'b0, ev_wr_hit = 1'b0, ev_wr_miss = 1'b0;
    logic       snp_hit = 1'b0, fill_done = 1'b0, push_done = 1'b0;
    logic [1:0] line_state;
    logic       fill_req, push_req, busy;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [1:0] S_I = 2'b00, S_E = 2'b01, S_M = 2'b10;
    // Stimulus codes {push_done, fill_done, snp_hit, wr_miss, wr_hit, rd_miss, rd_hit}
    localparam logic [6:0] D_RH = 7'b0000001, D_RM = 7'b0000010, D_WH = 7'b0000100,
                           D_WM = 7'b0001000, D_SN = 7'b0010000, D_FD = 7'b0100000,
                           D_PD = 7'b1000000, D_NO = 7'b0000000;

    mei_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_rd_hit(ev_rd_hit), .ev_rd_miss(ev_rd_miss),
        .ev_wr_hit(ev_wr_hit), .ev_wr_miss(ev_wr_miss),
        .snp_hit(snp_hit), .fill_done(fill_done), .push_done(push_done),
        .line_state(line_state), .fill_req(fill_req), .push_req(push_req), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [1:0] st, input logic f, input logic p);
        chk(req, "line_state", int'(line_state), int'(st));
        chk(req, "fill_req", int'(fill_req), int'(f));
        chk(req, "push_req", int'(push_req), int'(p));
    endtask

    // Apply one cycle of stimulus at a falling edge; return at the next falling edge.
    task automatic step(input logic [6:0] d);
        {push_done, fill_done, snp_hit, ev_wr_miss, ev_wr_hit, ev_rd_miss, ev_rd_hit} = d;
        @(negedge clk);
        {push_done, fill_done, snp_hit, ev_wr_miss, ev_wr_hit, ev_rd_miss, ev_rd_hit} = D_NO;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(D_NO);
        step(D_NO);
        rst_n = 1'b1;
    endtask

    task automatic go_exc();
        do_reset();
        step(D_RM);
        step(D_FD);
    endtask

    task automatic go_mod();
        do_reset();
        step(D_WM);
        step(D_FD);
    endtask

    task automatic t_reset();
        go_mod();
        step(D_SN);
        rst_n = 1'b0;
        step(D_NO);
        chk_out("R2", S_I, 1'b0, 1'b0);
        rst_n = 1'b1;
        chk("R2", "busy", int'(busy), 0);
        chk("R1", "state code", int'(line_state != 2'b11), 1);
    endtask

    task automatic t_read_miss();
        do_reset();
        step(D_RM);
        chk_out("R3", S_I, 1'b1, 1'b0);
        chk("R10", "busy during fill", int'(busy), 1);
        step(D_NO);
        chk_out("R3", S_I, 1'b1, 1'b0);
        step(D_FD);
        chk_out("R3", S_E, 1'b0, 1'b0);
        chk("R1", "exclusive code", int'(line_state), 1);
    endtask

    task automatic t_write_miss();
        do_reset();
        step(D_WM);
        chk_out("R4", S_I, 1'b1, 1'b0);
        step(D_WH);
        chk_out("R10", S_I, 1'b1, 1'b0);
        step(D_RM);
        step(D_FD);
        chk_out("R4", S_M, 1'b0, 1'b0);
    endtask

    task automatic t_write_hit();
        go_exc();
        step(D_WH);
        chk_out("R5", S_M, 1'b0, 1'b0);
        step(D_WH);
        chk_out("R5", S_M, 1'b0, 1'b0);
    endtask

    task automatic t_read_hit();
        go_exc();
        step(D_RH);
        chk_out("R6", S_E, 1'b0, 1'b0);
        go_mod();
        step(D_RH);
        chk_out("R6", S_M, 1'b0, 1'b0);
    endtask

    task automatic t_snoop_mod();
        go_mod();
        snp_hit = 1'b1;
        #1;
        chk("R10", "busy on snoop", int'(busy), 1);
        step(D_SN);
        chk_out("R7", S_M, 1'b0, 1'b1);
        step(D_RH);
        chk_out("R10", S_M, 1'b0, 1'b1);
        step(D_SN);
        chk_out("R12", S_M, 1'b0, 1'b1);
        step(D_PD);
        chk_out("R7", S_I, 1'b0, 1'b0);
        chk("R7", "busy after push", int'(busy), 0);
    endtask

    task automatic t_snoop_exc();
        go_exc();
        step(D_SN);
        chk_out("R8", S_I, 1'b0, 1'b0);
    endtask

    task automatic t_snoop_inv();
        do_reset();
        step(D_SN);
        chk_out("R9", S_I, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        go_exc();
        step(D_SN | D_WH);
        chk_out("R10", S_I, 1'b0, 1'b0);
        go_mod();
        step(D_SN | D_RH);
        chk_out("R10", S_M, 1'b0, 1'b1);
    endtask

    task automatic t_ignored();
        do_reset();
        step(D_RM | D_WM);
        chk_out("R11", S_I, 1'b0, 1'b0);
        step(D_WH);
        chk_out("R11", S_I, 1'b0, 1'b0);
        go_exc();
        step(D_RM);
        chk_out("R11", S_E, 1'b0, 1'b0);
        step(D_WM);
        chk_out("R11", S_E, 1'b0, 1'b0);
        step(D_WH | D_RH);
        chk_out("R11", S_E, 1'b0, 1'b0);
    endtask

    task automatic t_stray();
        do_reset();
        step(D_FD);
        chk_out("R12", S_I, 1'b0, 1'b0);
        step(D_PD);
        chk_out("R12", S_I, 1'b0, 1'b0);
        step(D_RM);
        step(D_SN);
        chk_out("R12", S_I, 1'b1, 1'b0);
        step(D_PD);
        chk_out("R12", S_I, 1'b1, 1'b0);
        step(D_FD);
        chk_out("R12", S_E, 1'b0, 1'b0);
        go_exc();
        step(D_FD);
        chk_out("R12", S_E, 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_write_miss();
        t_write_hit();
        t_read_hit();
        t_snoop_mod();
        t_snoop_exc();
        t_snoop_inv();
        t_priority();
        t_ignored();
        t_stray();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule